// File: doc/BRIEF.md
# Network Board Control and Parity Capture Registers

This block holds the control and status registers of a network interface board that carries a separate controller chip. Software reaches it through a 16-bit word-addressed register port. The block drives the controller's reset, attention, loopback-release and expansion-bus-enable lines. It merges the controller's interrupt and the board's parity-error condition into one interrupt request.

When the board's memory reports a parity error, the block records three things: the 20-bit failing word address, the source of the access and the failing byte lane. It keeps this record, and raises an error flag, until software writes an acknowledge bit. Errors that arrive while the flag is set are dropped, so the record always describes the first failure after the last acknowledge.

The register words sit above a page-map window (`MAP_WORDS` words) and an ID PROM window (`PROM_WORDS` words). Neither window is implemented here: those addresses read as zero and writes to them are ignored.

Top module: `board_ctl_top`

## Requirements
- R1: After reset, every control output is 0, `irq_o` is 0, and the status word reads back only the RAM configuration inputs.
- R2: Status word (offset `MAP_WORDS+PROM_WORDS`) bits 15 (reset), 14 (on-air), 13 (attention), 12 (interrupt enable), 11 (parity interrupt enable) and 5 (expansion bus enable) are read/write. Bit 15 drives `chip_reset_o`, bit 14 drives `on_air_o` and bit 5 drives `xbus_en_o`, each from the cycle after the write.
- R3: Status bits 9 (parity flag), 8 (controller interrupt, `chip_irq_i`), 4 (`ram_256k_i`) and 3:0 (`ram_base_i`) are read-only. All other status bits read 0. Writes to any read-only bit have no effect.
- R4: `irq_o` = (`chip_irq_i` AND status bit 12) OR (parity flag AND status bit 11).
- R5: `attn_o` is a single-cycle pulse when status bit 13 goes from 0 to 1. Rewriting the bit while it is already 1, or clearing it, gives no pulse.
- R6: A `par_err_i` strobe while the parity flag is clear sets the flag. In the same cycle it captures `par_addr_i`, `par_src_i` and `par_lane_i`.
- R7: While the flag is set, further strobes leave the captured address, source and lane unchanged.
- R8: A write to the parity control word (offset +2) with bit 8 set clears the flag. A write with bit 8 clear has no effect. Bit 8 always reads 0. This word reads source at bit 7, lane at bit 6 and address bits 19:16 at bits 3:0. The parity address word (offset +3) reads address bits 15:0.
- R9: A strobe in the same cycle as an acknowledge is captured as a new error, and the flag stays set.
- R10: The filler word (offset +1), the page-map and PROM windows, and addresses beyond offset +3 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 11 | Word address (width derived from window sizes) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| chip_irq_i | input | 1 | Controller interrupt level |
| ram_256k_i | input | 1 | RAM type strap |
| ram_base_i | input | 4 | RAM base address bits 20:17 strap |
| par_err_i | input | 1 | Parity error strobe |
| par_addr_i | input | 20 | Failing word address |
| par_src_i | input | 1 | Source of the failing access |
| par_lane_i | input | 1 | Failing byte lane |
| chip_reset_o | output | 1 | Controller reset |
| on_air_o | output | 1 | Leave loopback |
| attn_o | output | 1 | Attention pulse |
| xbus_en_o | output | 1 | Expansion bus enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench writes all 64 combinations of the writable status bits with the read-only bits forced to 1. A design that let a read-only bit latch, or dropped a writable one, fails on the readback. The bench also sweeps every combination of the interrupt sources and enables, which exposes a design that ignores one term or swaps the two enables. It checks the attention output for both an edge pulse and no pulse on a rewrite; a design that outputs the level, or pulses on every write, gives the wrong pulse count. It drives a second parity error while the flag is set and one in the same cycle as an acknowledge. A design that overwrites the record, or lets the acknowledge win, then shows the wrong captured address.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned PAR_AW  = 20;
  // status bit positions
  localparam int unsigned ST_RST  = 15;
  localparam int unsigned ST_AIR  = 14;
  localparam int unsigned ST_ATN  = 13;
  localparam int unsigned ST_IE   = 12;
  localparam int unsigned ST_PIE  = 11;
  localparam int unsigned ST_PERR = 9;
  localparam int unsigned ST_IRQ  = 8;
  localparam int unsigned ST_XBUS = 5;
  localparam int unsigned ST_RAMT = 4;
  localparam logic [DW-1:0] ST_WR_MASK = 16'hF820;
  // parity control bit positions
  localparam int unsigned PC_ACK  = 8;
  localparam int unsigned PC_SRC  = 7;
  localparam int unsigned PC_LANE = 6;
endpackage

// File: rtl/board_ctl_reg.sv
module board_ctl_reg
  import board_ctl_pkg::*;
#(
  parameter logic [DW-1:0] MASK = ST_WR_MASK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/board_attn_edge.sv
module board_attn_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_d <= 1'b0;
    else         level_d <= level_i;
  end
  assign pulse_o = level_i & ~level_d;
endmodule

// File: rtl/board_par_capture.sv
module board_par_capture
  import board_ctl_pkg::*;
#(
  parameter int unsigned AW = PAR_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          err_i,
  input  logic [AW-1:0] addr_i,
  input  logic          src_i,
  input  logic          lane_i,
  input  logic          ack_i,
  output logic          flag_o,
  output logic [AW-1:0] addr_o,
  output logic          src_o,
  output logic          lane_o
);
  // capture when the record is free, or is being freed this cycle
  logic take;
  assign take = err_i & (ack_i | ~flag_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      addr_o <= '0;
      src_o  <= 1'b0;
      lane_o <= 1'b0;
    end else begin
      if (ack_i)    flag_o <= err_i;
      else if (err_i) flag_o <= 1'b1;
      if (take) begin
        addr_o <= addr_i;
        src_o  <= src_i;
        lane_o <= lane_i;
      end
    end
  end
endmodule

// File: rtl/board_ctl_top.sv
module board_ctl_top
  import board_ctl_pkg::*;
#(
  parameter int unsigned MAP_WORDS  = 1024,
  parameter int unsigned PROM_WORDS = 32,
  localparam int unsigned ADDR_W = $clog2(MAP_WORDS + PROM_WORDS + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              chip_irq_i,
  input  logic              ram_256k_i,
  input  logic [3:0]        ram_base_i,
  input  logic              par_err_i,
  input  logic [PAR_AW-1:0] par_addr_i,
  input  logic              par_src_i,
  input  logic              par_lane_i,
  output logic              chip_reset_o,
  output logic              on_air_o,
  output logic              attn_o,
  output logic              xbus_en_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(MAP_WORDS + PROM_WORDS);
  localparam logic [ADDR_W-1:0] PCTL_OFS = STAT_OFS + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PADR_OFS = STAT_OFS + ADDR_W'(3);

  logic [DW-1:0]     ctl_q;
  logic              stat_wr, ack_w;
  logic              perr_q, psrc_q, plane_q;
  logic [PAR_AW-1:0] paddr_q;

  assign stat_wr = we_i && (addr_i == STAT_OFS);
  assign ack_w   = we_i && (addr_i == PCTL_OFS) && wdata_i[PC_ACK];

  board_ctl_reg #(.MASK(ST_WR_MASK)) u_ctl (
    .clk_i, .rst_ni, .wr_i(stat_wr), .wdata_i, .q_o(ctl_q)
  );

  board_attn_edge u_attn (
    .clk_i, .rst_ni, .level_i(ctl_q[ST_ATN]), .pulse_o(attn_o)
  );

  board_par_capture #(.AW(PAR_AW)) u_par (
    .clk_i, .rst_ni, .err_i(par_err_i), .addr_i(par_addr_i),
    .src_i(par_src_i), .lane_i(par_lane_i), .ack_i(ack_w),
    .flag_o(perr_q), .addr_o(paddr_q), .src_o(psrc_q), .lane_o(plane_q)
  );

  assign chip_reset_o = ctl_q[ST_RST];
  assign on_air_o     = ctl_q[ST_AIR];
  assign xbus_en_o    = ctl_q[ST_XBUS];
  assign irq_o = (chip_irq_i & ctl_q[ST_IE]) | (perr_q & ctl_q[ST_PIE]);

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_OFS) begin
      rdata_o          = ctl_q;
      rdata_o[ST_PERR] = perr_q;
      rdata_o[ST_IRQ]  = chip_irq_i;
      rdata_o[ST_RAMT] = ram_256k_i;
      rdata_o[3:0]     = ram_base_i;
    end else if (addr_i == PCTL_OFS) begin
      rdata_o[PC_SRC]  = psrc_q;
      rdata_o[PC_LANE] = plane_q;
      rdata_o[3:0]     = paddr_q[PAR_AW-1:16];
    end else if (addr_i == PADR_OFS) begin
      rdata_o = paddr_q[15:0];
    end
  end
endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk
  import board_ctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              attn_o,
  input logic              irq_o,
  input logic              chip_irq_i,
  input logic              par_err_i,
  input logic              ack_w,
  input logic              perr_q,
  input logic [PAR_AW-1:0] paddr_q,
  input logic [DW-1:0]     ctl_q
);
  p_attn_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |=> !attn_o);
  p_irq_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[ST_IE] && !ctl_q[ST_PIE]) |-> !irq_o);
  p_irq_chip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_irq_i && ctl_q[ST_IE]) |-> irq_o);
  p_err_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_i |=> perr_q);
  p_hold_rec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_q && !ack_w) |=> $stable(paddr_q));
  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && !par_err_i) |=> !perr_q);
endmodule

bind board_ctl_top board_ctl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .attn_o(attn_o), .irq_o(irq_o),
  .chip_irq_i(chip_irq_i), .par_err_i(par_err_i), .ack_w(ack_w),
  .perr_q(perr_q), .paddr_q(paddr_q), .ctl_q(ctl_q)
);

// File: tb/board_ctl_top_tb_top.sv
`timescale 1ns/1ps
module board_ctl_top_tb_top;
  localparam int MAPW = 1024, PROMW = 32, AW = 11;
  localparam logic [AW-1:0] STAT = AW'(MAPW + PROMW);
  localparam logic [AW-1:0] FILL = STAT + 1, PCTL = STAT + 2, PADR = STAT + 3;

  logic clk = 0, rst_n = 0;
  logic we = 0; logic [AW-1:0] addr = '0; logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic chip_irq = 0, r256 = 0; logic [3:0] rbase = '0;
  logic perr = 0, psrc = 0, plane = 0; logic [19:0] paddr = '0;
  logic rst_o, air_o, attn, xbus_o, irq;
  int total = 0, bad = 0, attn_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  board_ctl_top #(.MAP_WORDS(MAPW), .PROM_WORDS(PROMW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .chip_irq_i(chip_irq), .ram_256k_i(r256),
    .ram_base_i(rbase), .par_err_i(perr), .par_addr_i(paddr),
    .par_src_i(psrc), .par_lane_i(plane), .chip_reset_o(rst_o),
    .on_air_o(air_o), .attn_o(attn), .xbus_en_o(xbus_o), .irq_o(irq)
  );

  always @(negedge clk) if (attn) attn_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic inject(input logic [19:0] a, input logic s, input logic l);
    @(negedge clk); perr = 1; paddr = a; psrc = s; plane = l;
    @(negedge clk); perr = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, exp, prev;
    rbase = 4'hA; r256 = 1;
    #12 rst_n = 1;
    // R1 reset state
    rd(STAT, d);
    chk("R1 status", d, 16'h001A);
    chk("R1 outs", {rst_o, air_o, attn, xbus_o, irq}, 5'b0);

    // R2/R3 sweep writable bits with read-only bits forced high
    for (int v = 0; v < 64; v++) begin
      logic [15:0] w;
      w = {v[5], v[4], v[3], v[2], v[1], 5'b11111, v[0], 5'b11111};
      wr(STAT, w);
      rd(STAT, d);
      exp = (w & 16'hF820) | 16'h001A;
      chk("R2 R3 status rw", d, exp);
      chk("R2 outputs", {rst_o, air_o, xbus_o}, {w[15], w[14], w[5]});
    end
    wr(STAT, 16'h0000);
    // R3 read-only inputs sweep
    for (int v = 0; v < 32; v++) begin
      r256 = v[4]; rbase = v[3:0];
      rd(STAT, d);
      chk("R3 straps", d, {11'b0, v[4:0]});
    end

    // R4 interrupt combine
    for (int v = 0; v < 16; v++) begin
      wr(PCTL, 16'h0100);
      if (v[1]) inject(20'h1, 0, 0);
      wr(STAT, {3'b0, v[2], v[3], 11'b0});
      chip_irq = v[0];
      rd(STAT, d);
      chk("R4 irq_o", irq, (v[0] & v[2]) | (v[1] & v[3]));
      chk("R3 flags", {d[9], d[8]}, {v[1], v[0]});
    end
    chip_irq = 0; wr(STAT, 0); wr(PCTL, 16'h0100);

    // R5 attention pulse
    attn_cnt = 0;
    wr(STAT, 16'h2000); repeat (4) @(negedge clk);
    chk("R5 rising pulse", attn_cnt, 1);
    attn_cnt = 0;
    wr(STAT, 16'h2000); repeat (4) @(negedge clk);
    chk("R5 rewrite", attn_cnt, 0);
    wr(STAT, 16'h0000); repeat (4) @(negedge clk);
    chk("R5 clear", attn_cnt, 0);

    // R6 capture, R8 field layout
    inject(20'hB1234, 1, 0);
    rd(PCTL, d); chk("R6 R8 pctl", d, 16'h008B);
    rd(PADR, d); chk("R6 R8 paddr", d, 16'h1234);
    rd(STAT, d); chk("R6 flag", d[9], 1);
    // R7 second error ignored
    inject(20'h5ABCD, 0, 1);
    rd(PCTL, d); chk("R7 pctl hold", d, 16'h008B);
    rd(PADR, d); chk("R7 paddr hold", d, 16'h1234);
    // R8 write without ack bit
    wr(PCTL, 16'hFEFF);
    rd(STAT, d); chk("R8 no ack", d[9], 1);
    wr(PCTL, 16'h0100);
    rd(STAT, d); chk("R8 ack clears", d[9], 0);
    rd(PCTL, d); chk("R8 ack reads 0", d[8], 0);
    inject(20'h3C0DE, 0, 1);
    rd(PCTL, d); chk("R8 lane field", d, 16'h0043);
    rd(PADR, d); chk("R8 new addr", d, 16'hC0DE);

    // R9 coincident ack and error
    @(negedge clk); we = 1; addr = PCTL; wdata = 16'h0100;
    perr = 1; paddr = 20'h7EEEE; psrc = 1; plane = 1;
    @(negedge clk); we = 0; perr = 0;
    rd(STAT, d); chk("R9 flag stays", d[9], 1);
    rd(PADR, d); chk("R9 new capture", d, 16'hEEEE);
    rd(PCTL, d); chk("R9 pctl", d, 16'h00C7);

    // R10 other addresses
    wr(STAT, 16'h4000);
    rd(STAT, prev);
    foreach (d[i]) ;
    begin
      logic [AW-1:0] list [5];
      list = '{FILL, AW'(0), AW'(MAPW - 1), AW'(MAPW + 5), PADR + 1};
      for (int k = 0; k < 5; k++) begin
        wr(list[k], 16'hFFFF);
        rd(list[k], d); chk("R10 reads zero", d, 0);
        rd(STAT, d); chk("R10 status untouched", d, prev);
      end
    end
    chk("R10 outs untouched", {rst_o, air_o, xbus_o}, 3'b010);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule